// File: doc/BRIEF.md
# Slot Type-Code Serial Reporter

Each plug-in module on a shared backplane holds one copy of this block. After system reset is released it counts rising edges of a dedicated identification clock, and when the count reaches the window belonging to its own slot it sends its fixed type code one bit per clock on a single identification line that every module shares. Windows are `CODE_W` clocks long and are placed one after another by slot number. A scanning host can therefore learn the module type in every slot by toggling the clock and reading the line, and the modules never need to arbitrate for it.

While reset is asserted, the block samples the strapped slot number and the type code on every identification clock edge. Those sampled values are used until the next reset. Outside its own window the block drives the inactive (low) level, so its output can be combined with the outputs of other modules on a wired-OR line. Once its window has passed, the block stays silent until the next reset, however many more clocks arrive. A reset asserted during a window stops the window and restarts the count.

Top module: `slot_id_reporter`

## Requirements
- R1: While `id_rst` is high, `id_oe` and `id_data` are both 0 and the edge count is held at zero.
- R2: `slot_num` and `type_code` are sampled on every rising edge of `id_clk` while `id_rst` is high. Changes to them after reset is released have no effect until the next reset.
- R3: Let k be the number of `id_clk` rising edges since `id_rst` fell, with k = 0 before the first such edge. `id_oe` is 1 exactly when 8*slot <= k < 8*slot+8, where slot is the sampled slot number (0 to 15). This gives at most 8 driven cycles per reset.
- R4: Inside the window, at offset j = k - 8*slot, `id_data` equals bit 7-j of the sampled type code. The code is sent most significant bit first.
- R5: `id_data` is 0 whenever `id_oe` is 0, which is the inactive level of the wired-OR line.
- R6: After its window ends, the block keeps `id_oe` and `id_data` at 0 for every later edge until the next reset. The edge count saturates and does not wrap.
- R7: A reset asserted during a window ends the window at once. After the next release, the count and the window start again from k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_clk | input | 1 | Identification clock; each rising edge advances the count |
| id_rst | input | 1 | System reset, active high; clears the count asynchronously |
| slot_num | input | 4 | Slot number wired by the backplane |
| type_code | input | 8 | Fixed module type code |
| id_oe | output | 1 | High while this module owns the identification line |
| id_data | output | 1 | Serial code bit; low when not owning the line |

## Verification
The bound checker keeps its own count of edges since release and its own copies of the slot and code sampled during reset. On every edge it checks four things: that the line is quiet during reset, that the data line is low whenever the output enable is low, that every driven cycle falls in the window of the sampled slot and carries the correct bit of the sampled code, and that nothing is driven again once the window has closed. Some behaviour can only be shown by the bench's scenarios. These are the exact first and last cycle of each window, the absence of any window past the saturation point, the effect of inputs changed after release, and the restart after a reset in the middle of a window. The bench covers them by sweeping every slot with several codes and comparing each cycle against arithmetic expectations.

// File: rtl/slot_id_reporter.sv
module slot_id_reporter #(
  parameter int CODE_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic              id_clk,
  input  logic              id_rst,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [CODE_W-1:0] type_code,
  output logic              id_oe,
  output logic              id_data
);
  // CODE_W must be a power of two so a window is a field of the count
  localparam int BIT_W = $clog2(CODE_W);
  localparam int CNT_W = SLOT_W + BIT_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W) << SLOT_W;

  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot_q;
  logic [CODE_W-1:0] code_q;
  logic [BIT_W-1:0]  bit_idx;
  logic              in_win;

  always_ff @(posedge id_clk or posedge id_rst) begin
    if (id_rst)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge id_clk) begin
    if (id_rst) begin
      slot_q <= slot_num;
      code_q <= type_code;
    end
  end

  assign in_win  = (cnt[CNT_W-1:BIT_W] == {1'b0, slot_q});
  assign bit_idx = BIT_W'(CODE_W - 1) - cnt[BIT_W-1:0];
  assign id_oe   = in_win & ~id_rst;
  assign id_data = id_oe & code_q[bit_idx];
endmodule

module slot_id_reporter_chk #(
  parameter int CODE_W = 8,
  parameter int SLOT_W = 4
) (
  input logic              id_clk,
  input logic              id_rst,
  input logic [SLOT_W-1:0] slot_num,
  input logic [CODE_W-1:0] type_code,
  input logic              id_oe,
  input logic              id_data
);
  localparam int BIT_W = $clog2(CODE_W);
  localparam int TW    = SLOT_W + BIT_W + 2;
  localparam logic [TW-1:0] TMAX = TW'(CODE_W) << (SLOT_W + 1);

  logic [TW-1:0]     ticks;
  logic [SLOT_W-1:0] slot_s;
  logic [CODE_W-1:0] code_s;
  logic              oe_prev, closed;

  always_ff @(posedge id_clk) begin
    if (id_rst) begin
      ticks   <= '0;
      slot_s  <= slot_num;
      code_s  <= type_code;
      oe_prev <= 1'b0;
      closed  <= 1'b0;
    end else begin
      if (ticks != TMAX) ticks <= ticks + 1'b1;
      oe_prev <= id_oe;
      if (oe_prev && !id_oe) closed <= 1'b1;
    end
  end

  AST_QUIET_IN_RESET: assert property (@(posedge id_clk)
    id_rst |-> (!id_oe && !id_data)); // R1

  AST_IDLE_LEVEL_LOW: assert property (@(posedge id_clk) disable iff (id_rst)
    !id_oe |-> !id_data); // R5

  AST_WINDOW_OF_SLOT: assert property (@(posedge id_clk) disable iff (id_rst)
    id_oe |-> (ticks[TW-1:BIT_W] == {2'b00, slot_s})); // R3

  AST_MSB_FIRST_BIT: assert property (@(posedge id_clk) disable iff (id_rst)
    id_oe |-> (id_data == code_s[BIT_W'(CODE_W - 1) - ticks[BIT_W-1:0]])); // R4

  AST_SILENT_AFTER_WINDOW: assert property (@(posedge id_clk) disable iff (id_rst)
    closed |-> !id_oe); // R6
endmodule

bind slot_id_reporter slot_id_reporter_chk #(.CODE_W(CODE_W), .SLOT_W(SLOT_W)) u_chk (
  .id_clk(id_clk), .id_rst(id_rst), .slot_num(slot_num),
  .type_code(type_code), .id_oe(id_oe), .id_data(id_data)
);

// File: tb/slot_id_reporter_test.sv
module slot_id_reporter_test;
  logic       id_clk = 1'b0;
  logic       id_rst = 1'b1;
  logic [3:0] slot_num = '0;
  logic [7:0] type_code = '0;
  logic       id_oe, id_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 id_clk = ~id_clk;

  slot_id_reporter uut (
    .id_clk(id_clk), .id_rst(id_rst), .slot_num(slot_num),
    .type_code(type_code), .id_oe(id_oe), .id_data(id_data)
  );

  task automatic check(input string tag, input int k, input logic exp_oe, input logic exp_d);
    checks++;
    if (id_oe !== exp_oe || id_data !== exp_d) begin
      fails++;
      $display("FAIL %s k=%0d oe/data actual %b%b expected %b%b",
               tag, k, id_oe, id_data, exp_oe, exp_d);
    end
  endtask

  // R1 reset quiet, R3 window, R4 MSB first, R5 idle low, R6 silence after window
  task automatic scan(input string tag, input logic [3:0] s, input logic [7:0] c,
                      input int n, input bit scramble);
    @(negedge id_clk);
    id_rst = 1'b1; slot_num = s; type_code = c;
    repeat (2) @(negedge id_clk);
    #1 check({tag, " R1"}, -1, 1'b0, 1'b0);
    @(negedge id_clk);
    id_rst = 1'b0;
    if (scramble) begin // R2: post-release changes ignored
      slot_num = ~s; type_code = ~c;
    end
    for (int k = 0; k < n; k++) begin
      logic eo, ed;
      #1;
      eo = (k / 8 == int'(s));
      ed = eo ? c[7 - (k % 8)] : 1'b0;
      check(tag, k, eo, ed);
      @(negedge id_clk);
    end
  endtask

  initial begin
    logic [7:0] codes [4];
    for (int s = 0; s < 16; s++) begin
      codes[0] = 8'hA5;
      codes[1] = 8'h5A ^ {4'(s), 4'(s)};
      codes[2] = 8'hFF;
      codes[3] = 8'h01;
      for (int i = 0; i < 4; i++)
        scan("R3 R4 R5 sweep", 4'(s), codes[i], 140, 1'b0);
    end
    for (int s = 0; s < 16; s += 5)
      scan("R2 inputs after release", 4'(s), 8'hC3 ^ 8'(s), 140, 1'b1);
    scan("R6 long run", 4'd15, 8'hE7, 700, 1'b0);
    scan("R6 long run slot0", 4'd0, 8'h81, 700, 1'b0);
    scan("R7 abort", 4'd3, 8'h96, 28, 1'b0);
    scan("R7 restart", 4'd3, 8'h96, 140, 1'b0);
    scan("R7 abort slot9", 4'd9, 8'h6B, 75, 1'b0);
    scan("R7 restart slot2", 4'd2, 8'h6B, 140, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule